// File: doc/BRIEF.md
# Peripheral Security Access Filter

This block stands between a bus fabric and a group of up to `NUM_PERIPH` peripherals. For each access it decides, in the same cycle, whether the access may reach the addressed peripheral. It bases that decision on the peripheral's stored rules and on three attributes that come with the access: secure or not, privileged or not, and a 3-bit compartment ID. Each peripheral has four pieces of stored state: a secure-only bit, a privileged-only bit, a sticky lock bit, and a compartment word. The compartment word either names one static owner ID, or it lists the IDs that may use the peripheral while they hold its hardware semaphore. The semaphore block outside reports which ID currently owns the semaphore of the peripheral being accessed.

Software programs the rules through a simple write port and can read them back through a registered read port. The block enforces who may write which field. Only the trusted compartment ID may change compartment words, lock bits, the trusted-ID field and the global lock. A peripheral that has been locked keeps its rules until reset. Once the global lock is set, the whole configuration is frozen until reset.

Top module: `periph_access_filter`

## Requirements
- R1: After reset, all secure, privileged and lock bits and all compartment words are zero, the global lock is clear, and the trusted ID is `TDCID_RST` (default 1). An in-range peripheral therefore grants any access, and reads return zero except the trusted-ID field.
- R2: The secure bank starts at byte 0x10, one 32-bit word per 32 peripherals: peripheral p is bit p%32 of word 0x10+4*(p/32). When that bit is set, an access with the secure attribute low is denied.
- R3: The privileged bank starts at 0x30 and uses the same packing. When a peripheral's bit is set, an access with the privileged attribute low is denied.
- R4: Peripheral p's compartment word is at 0x100+8*p. Bit 0 enables ID filtering, bit 1 selects semaphore mode, bits 6:4 hold the static ID, and bits 23:16 hold an allow list with one bit per ID (bit 16+id). When bit 0 is clear, the access ID is not checked.
- R5: With filtering on and semaphore mode off, the access passes the ID check only if its ID equals bits 6:4.
- R6: With filtering on and semaphore mode on, the access passes the ID check only if its allow-list bit is set, `sem_busy` is high, and `sem_owner` equals the access ID.
- R7: The trusted ID sits in bits 6:4 of the word at 0xC00. Writes to compartment words, to the lock bank, to 0xC00 and to the control word at 0x000 take effect only when `cfg_wcid` equals the trusted ID. Writes from any other ID are ignored.
- R8: The lock bank at 0x50 (same packing) can only set bits. Writes to the secure bit, privileged bit or compartment word of a locked peripheral are ignored, and a lock bit clears only on reset.
- R9: Writing 1 to bit 0 of 0x000 sets the global lock. The bit reads back as 1, and from then on every write is ignored until reset.
- R10: An access index at or above `NUM_PERIPH` is always denied.
- R11: A read returns its data one cycle after `cfg_re` is sampled. Compartment words read back only their defined bits, and unmapped or misaligned addresses read as zero and ignore writes.
- R12: The grant is combinational from the stored rules and the current access inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Write byte address |
| cfg_wdata | input | 32 | Write data |
| cfg_wcid | input | 3 | Compartment ID of the writer |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_raddr | input | ADDR_W | Read byte address |
| cfg_rdata | output | 32 | Read data, registered |
| acc_idx | input | IDX_W | Index of the accessed peripheral |
| acc_sec | input | 1 | Access is secure |
| acc_priv | input | 1 | Access is privileged |
| acc_cid | input | 3 | Compartment ID of the access |
| sem_busy | input | 1 | Semaphore of the accessed peripheral is held |
| sem_owner | input | 3 | ID holding that semaphore |
| acc_grant | output | 1 | Access allowed |

## Verification
The assertions assume that `sem_busy` and `sem_owner` describe the semaphore of the peripheral on `acc_idx` in the same cycle. They also assume that reset is asserted before any write, so that the lock and freeze properties start from known state. The stimulus drives every input once per cycle, a little after the clock edge, and gives semaphore values that may or may not match the access ID. Random writes set lock bits only rarely, so most peripherals stay programmable during the random phase, and the global lock is written only at the very end.

// File: rtl/afw_pkg.sv
package afw_pkg;
  localparam int CID_W   = 3;
  localparam int NUM_CID = 1 << CID_W;

  typedef struct packed {
    logic [NUM_CID-1:0] allow;
    logic [CID_W-1:0]   scid;
    logic               sem_en;
    logic               flt_en;
  } cid_cfg_t;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_SEC, RG_PRIV, RG_LOCK, RG_CIDW, RG_INIT
  } afw_region_e;

  function automatic cid_cfg_t unpack_cid(input logic [31:0] w);
    cid_cfg_t c;
    c.flt_en = w[0];
    c.sem_en = w[1];
    c.scid   = w[6:4];
    c.allow  = w[23:16];
    return c;
  endfunction

  function automatic logic [31:0] pack_cid(input cid_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[0]     = c.flt_en;
    w[1]     = c.sem_en;
    w[6:4]   = c.scid;
    w[23:16] = c.allow;
    return w;
  endfunction
endpackage

// File: rtl/afw_cfg_regs.sv
module afw_cfg_regs
  import afw_pkg::*;
#(
  parameter int NUM_PERIPH = 128,
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = $clog2(NUM_PERIPH) + 1,
  parameter int TDCID_RST  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [CID_W-1:0]  wr_cid,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [IDX_W-1:0]  look_idx,
  output logic              look_ok,
  output logic              look_sec,
  output logic              look_priv,
  output cid_cfg_t          look_cfg
);
  localparam int PW        = $clog2(NUM_PERIPH);
  localparam int NWORD     = (NUM_PERIPH + 31) / 32;
  localparam int CTRL_ADDR = 'h000;
  localparam int SEC_BASE  = 'h010;
  localparam int PRIV_BASE = 'h030;
  localparam int LOCK_BASE = 'h050;
  localparam int CIDW_BASE = 'h100;
  localparam int INIT_ADDR = 'hC00;
  localparam int CIDW_END  = CIDW_BASE + 8 * NUM_PERIPH;
  localparam logic [IDX_W-1:0] NP_IDX = IDX_W'(NUM_PERIPH);

  logic [NUM_PERIPH-1:0] sec_q, priv_q, lock_q;
  logic [NUM_PERIPH-1:0] sec_d, priv_d, lock_d;
  cid_cfg_t              cid_q [NUM_PERIPH];
  logic                  glock_q, glock_d;
  logic [CID_W-1:0]      tdcid_q, tdcid_d;
  logic                  cid_we, trusted;
  afw_region_e           wr_rgn, rd_rgn;
  int                    wr_slot, rd_slot;
  logic [PW-1:0]         wr_pidx, rd_pidx, lk_pidx;
  logic [31:0]           rd_word;

  function automatic afw_region_e rgn_of(input logic [ADDR_W-1:0] a);
    int ai;
    ai = int'(a);
    if (ai == CTRL_ADDR) return RG_CTRL;
    if (ai == INIT_ADDR) return RG_INIT;
    if (a[1:0] != 2'b00) return RG_NONE;
    if (ai >= SEC_BASE  && ai < SEC_BASE  + 4 * NWORD) return RG_SEC;
    if (ai >= PRIV_BASE && ai < PRIV_BASE + 4 * NWORD) return RG_PRIV;
    if (ai >= LOCK_BASE && ai < LOCK_BASE + 4 * NWORD) return RG_LOCK;
    if (ai >= CIDW_BASE && ai < CIDW_END && a[2] == 1'b0) return RG_CIDW;
    return RG_NONE;
  endfunction

  function automatic int slot_of(input logic [ADDR_W-1:0] a, input afw_region_e r);
    case (r)
      RG_SEC:  return (int'(a) - SEC_BASE) / 4;
      RG_PRIV: return (int'(a) - PRIV_BASE) / 4;
      RG_LOCK: return (int'(a) - LOCK_BASE) / 4;
      RG_CIDW: return (int'(a) - CIDW_BASE) / 8;
      default: return 0;
    endcase
  endfunction

  always_comb begin
    wr_rgn  = rgn_of(wr_addr);
    wr_slot = slot_of(wr_addr, wr_rgn);
    wr_pidx = PW'(wr_slot);
    rd_rgn  = rgn_of(rd_addr);
    rd_slot = slot_of(rd_addr, rd_rgn);
    rd_pidx = PW'(rd_slot);
    trusted = (wr_cid == tdcid_q);
  end

  // next-state of the bit banks and control fields under the write rules
  always_comb begin
    sec_d   = sec_q;
    priv_d  = priv_q;
    lock_d  = lock_q;
    glock_d = glock_q;
    tdcid_d = tdcid_q;
    cid_we  = 1'b0;
    if (wr_en && !glock_q) begin
      case (wr_rgn)
        RG_CTRL: if (trusted && wr_data[0]) glock_d = 1'b1;
        RG_INIT: if (trusted) tdcid_d = wr_data[6:4];
        RG_SEC, RG_PRIV, RG_LOCK: begin
          for (int b = 0; b < NUM_PERIPH; b++) begin
            if ((b >> 5) == wr_slot) begin
              if (wr_rgn == RG_SEC && !lock_q[b])  sec_d[b]  = wr_data[5'(b)];
              if (wr_rgn == RG_PRIV && !lock_q[b]) priv_d[b] = wr_data[5'(b)];
              if (wr_rgn == RG_LOCK && trusted)    lock_d[b] = lock_q[b] | wr_data[5'(b)];
            end
          end
        end
        RG_CIDW: cid_we = trusted && !lock_q[wr_pidx];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q   <= '0;
      priv_q  <= '0;
      lock_q  <= '0;
      glock_q <= 1'b0;
      tdcid_q <= CID_W'(TDCID_RST);
      for (int i = 0; i < NUM_PERIPH; i++) cid_q[i] <= '0;
    end else begin
      sec_q   <= sec_d;
      priv_q  <= priv_d;
      lock_q  <= lock_d;
      glock_q <= glock_d;
      tdcid_q <= tdcid_d;
      if (cid_we) cid_q[wr_pidx] <= unpack_cid(wr_data);
    end
  end

  always_comb begin
    rd_word = '0;
    case (rd_rgn)
      RG_CTRL: rd_word[0]   = glock_q;
      RG_INIT: rd_word[6:4] = tdcid_q;
      RG_SEC, RG_PRIV, RG_LOCK: begin
        for (int b = 0; b < NUM_PERIPH; b++) begin
          if ((b >> 5) == rd_slot)
            rd_word[5'(b)] = (rd_rgn == RG_SEC)  ? sec_q[b] :
                             (rd_rgn == RG_PRIV) ? priv_q[b] : lock_q[b];
        end
      end
      RG_CIDW: rd_word = pack_cid(cid_q[rd_pidx]);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  always_comb begin
    look_ok   = (look_idx < NP_IDX);
    lk_pidx   = PW'(look_idx);
    look_sec  = look_ok && sec_q[lk_pidx];
    look_priv = look_ok && priv_q[lk_pidx];
    look_cfg  = look_ok ? cid_q[lk_pidx] : '0;
  end

  // R9
  glock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    glock_q |=> glock_q);
  // R9
  glock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    glock_q |=> ($stable(sec_q) && $stable(priv_q) && $stable(lock_q) && $stable(tdcid_q)));
  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q != '0) |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
  // R7
  untrusted_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_cid != tdcid_q) |=> ($stable(tdcid_q) && $stable(lock_q) && $stable(glock_q)));

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_frz
    // R8
    locked_entry_chk: assert property (@(posedge clk) disable iff (rst)
      lock_q[g] |=> ($stable(cid_q[g]) && $stable(sec_q[g]) && $stable(priv_q[g])));
  end
endmodule

// File: rtl/afw_decide.sv
module afw_decide
  import afw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_range,
  input  logic             p_sec,
  input  logic             p_priv,
  input  cid_cfg_t         cfg,
  input  logic             acc_sec,
  input  logic             acc_priv,
  input  logic [CID_W-1:0] acc_cid,
  input  logic             sem_busy,
  input  logic [CID_W-1:0] sem_owner,
  output logic             grant
);
  logic sec_ok, priv_ok, cid_ok, held, listed;

  always_comb begin
    sec_ok  = !p_sec || acc_sec;
    priv_ok = !p_priv || acc_priv;
    held    = sem_busy && (sem_owner == acc_cid);
    listed  = cfg.allow[acc_cid];
    if (!cfg.flt_en)     cid_ok = 1'b1;
    else if (cfg.sem_en) cid_ok = listed && held;
    else                 cid_ok = (cfg.scid == acc_cid);
    grant = in_range && sec_ok && priv_ok && cid_ok;
  end

  // R10
  oor_deny_chk: assert property (@(posedge clk) disable iff (rst)
    !in_range |-> !grant);
  // R2
  sec_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (p_sec && !acc_sec) |-> !grant);
  // R3
  priv_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (p_priv && !acc_priv) |-> !grant);
  // R6
  sem_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && cfg.flt_en && cfg.sem_en) |-> (sem_busy && sem_owner == acc_cid));
endmodule

// File: rtl/periph_access_filter.sv
module periph_access_filter
  import afw_pkg::*;
#(
  parameter int NUM_PERIPH = 128,
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = $clog2(NUM_PERIPH) + 1,
  parameter int TDCID_RST  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [2:0]        cfg_wcid,
  input  logic              cfg_re,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [31:0]       cfg_rdata,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic              acc_sec,
  input  logic              acc_priv,
  input  logic [2:0]        acc_cid,
  input  logic              sem_busy,
  input  logic [2:0]        sem_owner,
  output logic              acc_grant
);
  logic     lk_ok, lk_sec, lk_priv;
  cid_cfg_t lk_cfg;

  afw_cfg_regs #(
    .NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TDCID_RST(TDCID_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata), .wr_cid(cfg_wcid),
    .rd_en(cfg_re), .rd_addr(cfg_raddr), .rd_data(cfg_rdata),
    .look_idx(acc_idx), .look_ok(lk_ok), .look_sec(lk_sec), .look_priv(lk_priv),
    .look_cfg(lk_cfg)
  );

  afw_decide u_decide (
    .clk(clk), .rst(rst),
    .in_range(lk_ok), .p_sec(lk_sec), .p_priv(lk_priv), .cfg(lk_cfg),
    .acc_sec(acc_sec), .acc_priv(acc_priv), .acc_cid(acc_cid),
    .sem_busy(sem_busy), .sem_owner(sem_owner), .grant(acc_grant)
  );
endmodule

// File: tb/periph_access_filter_bench.sv
`timescale 1ns/1ps
module periph_access_filter_bench;
  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [11:0] cfg_addr = '0, cfg_raddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_wcid = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  acc_idx = '0;
  logic        acc_sec = 1'b0, acc_priv = 1'b0, sem_busy = 1'b0;
  logic [2:0]  acc_cid = '0, sem_owner = '0;
  logic        acc_grant;

  int    errors = 0, checks = 0;
  bit    started = 0, done = 0;
  string cur_tag = "R1";

  // behavioural reference state
  bit          m_sec [N], m_priv [N], m_lock [N];
  logic [31:0] m_cid [N];
  bit          m_glock;
  logic [2:0]  m_tdcid;
  bit          rd_pend;
  logic [31:0] exp_rd;

  always #10 clk = ~clk;

  periph_access_filter u_periph_access_filter (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_wcid(cfg_wcid),
    .cfg_re(cfg_re), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .acc_idx(acc_idx), .acc_sec(acc_sec), .acc_priv(acc_priv), .acc_cid(acc_cid),
    .sem_busy(sem_busy), .sem_owner(sem_owner), .acc_grant(acc_grant)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int ai = int'(a);
    logic [31:0] r = '0;
    if (ai == 0) r[0] = m_glock;
    else if (ai == 'hC00) r[6:4] = m_tdcid;
    else if (ai % 4 == 0 && ai >= 'h10 && ai < 'h20)
      for (int b = 0; b < 32; b++) r[b] = m_sec[(ai - 'h10) / 4 * 32 + b];
    else if (ai % 4 == 0 && ai >= 'h30 && ai < 'h40)
      for (int b = 0; b < 32; b++) r[b] = m_priv[(ai - 'h30) / 4 * 32 + b];
    else if (ai % 4 == 0 && ai >= 'h50 && ai < 'h60)
      for (int b = 0; b < 32; b++) r[b] = m_lock[(ai - 'h50) / 4 * 32 + b];
    else if (ai % 8 == 0 && ai >= 'h100 && ai < 'h100 + 8 * N)
      r = m_cid[(ai - 'h100) / 8];
    return r;
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [31:0] d, input logic [2:0] c);
    int ai = int'(a);
    bit tr = (c == m_tdcid);
    if (m_glock) return;
    if (ai == 0) begin
      if (tr && d[0]) m_glock = 1;
    end else if (ai == 'hC00) begin
      if (tr) m_tdcid = d[6:4];
    end else if (ai % 4 == 0 && ai >= 'h10 && ai < 'h20) begin
      for (int b = 0; b < 32; b++) begin
        int p = (ai - 'h10) / 4 * 32 + b;
        if (!m_lock[p]) m_sec[p] = d[b];
      end
    end else if (ai % 4 == 0 && ai >= 'h30 && ai < 'h40) begin
      for (int b = 0; b < 32; b++) begin
        int p = (ai - 'h30) / 4 * 32 + b;
        if (!m_lock[p]) m_priv[p] = d[b];
      end
    end else if (ai % 4 == 0 && ai >= 'h50 && ai < 'h60) begin
      for (int b = 0; b < 32; b++) begin
        int p = (ai - 'h50) / 4 * 32 + b;
        if (tr && d[b]) m_lock[p] = 1;
      end
    end else if (ai % 8 == 0 && ai >= 'h100 && ai < 'h100 + 8 * N) begin
      int p = (ai - 'h100) / 8;
      if (tr && !m_lock[p]) m_cid[p] = d & 32'h00FF_0073;
    end
  endtask

  function automatic bit m_grant(input int idx, input bit s, input bit p, input int cid,
                                 input bit busy, input int own);
    logic [31:0] w;
    bit ok;
    if (idx >= N) return 0;
    w  = m_cid[idx];
    ok = (!m_sec[idx] || s) && (!m_priv[idx] || p);
    if (w[0]) begin
      if (w[1]) ok = ok && w[16 + cid] && busy && (own == cid);
      else      ok = ok && (int'(w[6:4]) == cid);
    end
    return ok;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_sec[i] = 0; m_priv[i] = 0; m_lock[i] = 0; m_cid[i] = '0;
      end
      m_glock = 0;
      m_tdcid = 3'd1;
      rd_pend = 0;
      started = 1;
    end else begin
      rd_pend = cfg_re;
      if (cfg_re) exp_rd = m_read(cfg_raddr);
      if (cfg_we) m_write(cfg_addr, cfg_wdata, cfg_wcid);
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      chk(cur_tag, "grant vs model", 32'(acc_grant),
          32'(m_grant(int'(acc_idx), acc_sec, acc_priv, int'(acc_cid), sem_busy, int'(sem_owner))));
      if (rd_pend && !rst) chk(cur_tag, "rdata vs model", cfg_rdata, exp_rd);
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input int c);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 12'(a); cfg_wdata = d; cfg_wcid = 3'(c);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    cfg_re = 1'b1; cfg_raddr = 12'(a);
    @(posedge clk); #1;
    cfg_re = 1'b0;
    @(negedge clk);
    chk(tag, "readback", cfg_rdata, exp);
  endtask

  task automatic acc(input int idx, input bit s, input bit p, input int cid, input bit busy,
                     input int own, input bit exp, input string tag);
    @(posedge clk); #1;
    acc_idx = 8'(idx); acc_sec = s; acc_priv = p; acc_cid = 3'(cid);
    sem_busy = busy; sem_owner = 3'(own);
    @(negedge clk);
    chk(tag, "grant", 32'(acc_grant), 32'(exp));
  endtask

  initial begin
    logic [31:0] keep;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    cur_tag = "R1";
    acc(0, 0, 0, 7, 0, 0, 1, "R1");
    acc(127, 0, 0, 3, 0, 0, 1, "R1");
    rd('h14, 32'h0, "R1");
    rd('hC00, 32'h10, "R1");

    cur_tag = "R2";
    wr('h14, 32'h20, 0);
    acc(37, 0, 1, 0, 0, 0, 0, "R2");
    acc(37, 1, 0, 0, 0, 0, 1, "R2");
    acc(36, 0, 0, 0, 0, 0, 1, "R2");

    cur_tag = "R3";
    wr('h3C, 32'h10, 3);
    acc(100, 1, 0, 2, 0, 0, 0, "R3");
    acc(100, 0, 1, 2, 0, 0, 1, "R3");

    cur_tag = "R4";
    wr('h130, 32'h30, 1);
    acc(6, 0, 0, 5, 0, 0, 1, "R4");

    cur_tag = "R5";
    wr('h128, 32'h31, 1);
    acc(5, 0, 0, 3, 0, 0, 1, "R5");
    acc(5, 0, 0, 2, 0, 0, 0, "R5");
    rd('h128, 32'h31, "R5");

    cur_tag = "R6";
    wr('h148, 32'h0024_0003, 1);
    acc(9, 0, 0, 2, 1, 2, 1, "R6");
    acc(9, 0, 0, 2, 0, 2, 0, "R6");
    acc(9, 0, 0, 2, 1, 5, 0, "R6");
    acc(9, 0, 0, 3, 1, 3, 0, "R6");
    acc(9, 0, 0, 5, 1, 5, 1, "R6");

    cur_tag = "R11";
    wr('h150, 32'hFFFF_FFFF, 1);
    rd('h150, 32'h00FF_0073, "R11");
    wr('h154, 32'hFFFF_FFFF, 1);
    rd('h154, 32'h0, "R11");
    wr('h11, 32'hFFFF_FFFF, 1);
    rd('h10, 32'h0, "R11");

    cur_tag = "R7";
    wr('h128, 32'h21, 4);
    rd('h128, 32'h31, "R7");
    acc(5, 0, 0, 3, 0, 0, 1, "R7");
    wr('h54, 32'h1, 0);
    rd('h54, 32'h0, "R7");
    wr('hC00, 32'h40, 1);
    rd('hC00, 32'h40, "R7");
    wr('h128, 32'h21, 1);
    rd('h128, 32'h31, "R7");
    wr('h128, 32'h21, 4);
    rd('h128, 32'h21, "R7");
    acc(5, 0, 0, 2, 0, 0, 1, "R7");

    cur_tag = "R8";
    wr('h50, 32'h20, 4);
    wr('h50, 32'h0, 4);
    rd('h50, 32'h20, "R8");
    wr('h10, 32'h60, 0);
    rd('h10, 32'h40, "R8");
    acc(5, 0, 0, 2, 0, 0, 1, "R8");
    wr('h128, 32'h31, 4);
    rd('h128, 32'h21, "R8");

    cur_tag = "R10";
    acc(128, 1, 1, 0, 0, 0, 0, "R10");
    acc(200, 1, 1, 0, 1, 0, 0, "R10");

    cur_tag = "R12";
    for (int i = 0; i < 800; i++) begin
      int kind;
      int a;
      @(posedge clk); #1;
      kind = $urandom_range(0, 9);
      case (kind)
        0, 1: a = 'h10 + 4 * $urandom_range(0, 3);
        2, 3: a = 'h30 + 4 * $urandom_range(0, 3);
        4:    a = 'h50 + 4 * $urandom_range(0, 3);
        5, 6, 7: a = 'h100 + 8 * $urandom_range(0, N - 1);
        8:    a = 'hC00;
        default: a = $urandom_range(1, 'h4FF);
      endcase
      cfg_we    = ($urandom_range(0, 2) == 0);
      cfg_addr  = 12'(a);
      cfg_wdata = $urandom();
      if (kind == 4) cfg_wdata = ($urandom_range(0, 7) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0;
      cfg_wcid  = ($urandom_range(0, 1) == 0) ? m_tdcid : 3'($urandom_range(0, 7));
      cfg_re    = $urandom_range(0, 1);
      cfg_raddr = ($urandom_range(0, 3) == 0) ? 12'($urandom_range(0, 'hFFF))
                                              : 12'('h100 + 8 * $urandom_range(0, N - 1));
      acc_idx   = 8'($urandom_range(0, 140));
      acc_sec   = $urandom_range(0, 1);
      acc_priv  = $urandom_range(0, 1);
      acc_cid   = 3'($urandom_range(0, 7));
      sem_busy  = $urandom_range(0, 1);
      sem_owner = ($urandom_range(0, 1) == 0) ? acc_cid : 3'($urandom_range(0, 7));
    end
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_re = 1'b0;

    cur_tag = "R9";
    wr('h0, 32'h1, int'(m_tdcid));
    rd('h0, 32'h1, "R9");
    rd('h18, m_read(12'h18), "R9");
    keep = cfg_rdata;
    wr('h18, ~keep, int'(m_tdcid));
    rd('h18, keep, "R9");
    wr('h0, 32'h0, int'(m_tdcid));
    rd('h0, 32'h1, "R9");

    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule